// File: doc/BRIEF.md
# GF(16) Arithmetic Operation Unit

This unit performs arithmetic on 4-bit elements of the finite field GF(2^4). Each element is a polynomial of degree three or less over GF(2), with bit i holding the coefficient of x^i, and every result is reduced modulo x^4 + x + 1. A 2-bit opcode selects the operation. It can multiply two operands, invert one operand, or square one operand and multiply the square by the fixed constant x^3 + x^2 + x. A fourth code passes operand A through unchanged.

The unit is the nibble-level engine of a composite-field byte substitution. A caller builds the byte inverse from a handful of these operations, so every result must be exact to the field definition. The multiplier forms shifted partial products, XORs them together and then reduces the sum. The inverter is a 16-entry table that sends zero to zero. The square-times-constant path is a fixed linear squaring feeding a constant multiplier.

By default the result is registered. A strobe on `in_valid` loads the selected result, and `out_valid` pulses in the following cycle. A parameter removes the register and leaves a purely combinational path.

Top module: `gf16_alu`

## Requirements
- R1: With opcode 2'b00 the result is opa · opb reduced modulo x^4 + x + 1, for all 256 operand pairs (bit i of each nibble is the coefficient of x^i).
- R2: With opcode 2'b01 the result is the inverse of opa. An input of 4'h0 gives 4'h0, and every nonzero opa gives the element whose product with opa is 4'h1.
- R3: Inverting the inverse of any of the 16 values gives back the original value.
- R4: Multiplying by 4'h0 gives 4'h0, and multiplying by 4'h1 gives the other operand unchanged.
- R5: With opcode 2'b10 the result is opa^2 · λ, where λ = x^3 + x^2 + x = 4'b1110.
- R6: With opcode 2'b11 the result equals opa. For opcodes 2'b01, 2'b10 and 2'b11, opb has no effect on the result.
- R7: In the registered build, out_valid is high exactly one cycle after a cycle with in_valid high, and low one cycle after a cycle with in_valid low. The result for a strobe appears together with its out_valid.
- R8: A synchronous active-high reset drives res to 4'h0 and out_valid to 0 at the next clock edge.
- R9: In the registered build, res keeps its last value across cycles in which in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| op | input | 2 | Operation code: 00 multiply, 01 inverse, 10 square times λ, 11 pass A |
| opa | input | 4 | First operand |
| opb | input | 4 | Second operand, used by multiply only |
| res | output | 4 | Result |
| out_valid | output | 1 | Result strobe |

## Verification
The bench sweeps all 256 multiply pairs, so any wrong reduction tap or any dropped partial product shows up as a wrong product for some high-degree operand pair. Zero is covered for both the multiplier and the inverter; an inverter that does not send zero to zero, or a multiplier that lets a stale partial product through, produces a nonzero result there. Every nonzero value is checked twice: its product with its own inverse must be one, and inverting the inverse must give the value back, which catches a single swapped table entry. Random opb values during the unary opcodes expose a mux that leaks the second operand. Idle gaps and a reset in mid-run expose a register that reloads without a strobe or fails to clear.

// File: rtl/gf16_pkg.sv
package gf16_pkg;

    localparam int        FIELD_W  = 4;
    localparam int        PROD_W   = 2 * FIELD_W - 1;
    localparam logic [FIELD_W:0] FIELD_POLY = 5'b10011;   // x^4 + x + 1
    localparam logic [FIELD_W-1:0] LAMBDA   = 4'b1110;    // x^3 + x^2 + x

    typedef logic [FIELD_W-1:0] gf_t;

    typedef enum logic [1:0] {
        OP_MUL  = 2'b00,
        OP_INV  = 2'b01,
        OP_SQL  = 2'b10,
        OP_PASS = 2'b11
    } gf_op_e;

    typedef struct packed {
        gf_op_e op;
        gf_t    a;
        gf_t    b;
    } gf_req_t;

    typedef struct packed {
        logic valid;
        gf_t  value;
    } gf_rsp_t;

    // Squaring is linear in characteristic 2:
    // (a0 + a1x + a2x^2 + a3x^3)^2 = a0 + a1x^2 + a2(x+1) + a3(x^3+x^2)
    function automatic gf_t gf_square(input gf_t q);
        gf_t s;
        s[0] = q[0] ^ q[2];
        s[1] = q[2];
        s[2] = q[1] ^ q[3];
        s[3] = q[3];
        return s;
    endfunction

endpackage

// File: rtl/gf16_mul.sv
module gf16_mul #(
    parameter int              W    = gf16_pkg::FIELD_W,
    parameter logic [W:0]      POLY = gf16_pkg::FIELD_POLY
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] p
);
    localparam int PW = 2 * W - 1;

    logic [PW-1:0] partial [W];
    logic [PW-1:0] wide;

    // one shifted copy of a for every set bit of b
    for (genvar i = 0; i < W; i++) begin : g_pp
        assign partial[i] = b[i] ? (PW'(a) << i) : '0;
    end

    always_comb begin
        wide = '0;
        for (int k = 0; k < W; k++) begin
            wide = wide ^ partial[k];
        end
        // fold the high terms down, highest degree first
        for (int k = PW - 1; k >= W; k--) begin
            if (wide[k]) begin
                wide = wide ^ (PW'(POLY) << (k - W));
            end
        end
        p = wide[W-1:0];
    end

endmodule

// File: rtl/gf16_inv.sv
module gf16_inv
    import gf16_pkg::*;
(
    input  gf_t a,
    output gf_t y
);
    always_comb begin
        unique case (a)
            4'h0: y = 4'h0;
            4'h1: y = 4'h1;
            4'h2: y = 4'h9;
            4'h3: y = 4'he;
            4'h4: y = 4'hd;
            4'h5: y = 4'hb;
            4'h6: y = 4'h7;
            4'h7: y = 4'h6;
            4'h8: y = 4'hf;
            4'h9: y = 4'h2;
            4'ha: y = 4'hc;
            4'hb: y = 4'h5;
            4'hc: y = 4'ha;
            4'hd: y = 4'h4;
            4'he: y = 4'h3;
            default: y = 4'h8;
        endcase
    end

endmodule

// File: rtl/gf16_sqlam.sv
module gf16_sqlam
    import gf16_pkg::*;
(
    input  gf_t q,
    output gf_t y
);
    gf_t sq;

    assign sq = gf_square(q);

    gf16_mul #(
        .W    (FIELD_W),
        .POLY (FIELD_POLY)
    ) i_cmul (
        .a (sq),
        .b (LAMBDA),
        .p (y)
    );

endmodule

// File: rtl/gf16_alu.sv
module gf16_alu
    import gf16_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [1:0] op,
    input  logic [3:0] opa,
    input  logic [3:0] opb,
    output logic [3:0] res,
    output logic       out_valid
);
    gf_req_t req;
    gf_t     mul_y;
    gf_t     inv_y;
    gf_t     sql_y;
    gf_rsp_t rsp_d;

    assign req.op = gf_op_e'(op);
    assign req.a  = opa;
    assign req.b  = opb;

    gf16_mul #(
        .W    (FIELD_W),
        .POLY (FIELD_POLY)
    ) i_mul (
        .a (req.a),
        .b (req.b),
        .p (mul_y)
    );

    gf16_inv i_inv (
        .a (req.a),
        .y (inv_y)
    );

    gf16_sqlam i_sql (
        .q (req.a),
        .y (sql_y)
    );

    always_comb begin
        rsp_d.valid = in_valid;
        unique case (req.op)
            OP_MUL:  rsp_d.value = mul_y;
            OP_INV:  rsp_d.value = inv_y;
            OP_SQL:  rsp_d.value = sql_y;
            default: rsp_d.value = req.a;
        endcase
    end

    if (REGISTERED) begin : g_reg
        gf_rsp_t rsp_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                rsp_q <= '0;
            end else begin
                rsp_q.valid <= rsp_d.valid;
                if (rsp_d.valid) begin
                    rsp_q.value <= rsp_d.value;
                end
            end
        end

        assign res       = rsp_q.value;
        assign out_valid = rsp_q.valid;
    end else begin : g_comb
        assign res       = rsp_d.value;
        assign out_valid = rsp_d.valid;
    end

endmodule

// File: rtl/gf16_alu_chk.sv
module gf16_alu_chk #(
    parameter bit REGISTERED = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [1:0] op,
    input logic [3:0] opa,
    input logic [3:0] opb,
    input logic [3:0] res,
    input logic       out_valid
);
    if (REGISTERED) begin : g_seq
        p_valid_follows_r7: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);

        p_valid_drops_r7: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);

        p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> $stable(res));

        p_pass_a_r6: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op == 2'b11) |=> (res == $past(opa)));

        p_inv_zero_r2: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op == 2'b01 && opa == 4'h0) |=> (res == 4'h0));

        p_mul_by_zero_r4: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op == 2'b00 && (opa == 4'h0 || opb == 4'h0)) |=> (res == 4'h0));

        p_mul_by_one_r4: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op == 2'b00 && opb == 4'h1) |=> (res == $past(opa)));

        p_sql_zero_r5: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op == 2'b10 && opa == 4'h0) |=> (res == 4'h0));
    end else begin : g_cmb
        always_comb begin
            if (in_valid && op == 2'b11) begin
                p_pass_comb_r6: assert (res == opa);
            end
        end
    end

endmodule

bind gf16_alu gf16_alu_chk #(
    .REGISTERED (REGISTERED)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .opa       (opa),
    .opb       (opb),
    .res       (res),
    .out_valid (out_valid)
);

// File: tb/test_gf16_alu.sv
module test_gf16_alu;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [1:0] op = 2'b00;
    logic [3:0] opa = 4'h0;
    logic [3:0] opb = 4'h0;
    logic [3:0] res;
    logic       out_valid;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    bit armed    = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    gf16_alu #(.REGISTERED(1'b1)) i_gf16_alu (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op        (op),
        .opa       (opa),
        .opb       (opb),
        .res       (res),
        .out_valid (out_valid)
    );

    // behavioural field arithmetic
    function automatic int f_mul(input int a, input int b);
        int acc = 0;
        for (int i = 0; i < 4; i++) if ((b >> i) & 1) acc = acc ^ (a << i);
        for (int k = 6; k >= 4; k--) if ((acc >> k) & 1) acc = acc ^ (19 << (k - 4));
        return acc & 15;
    endfunction

    function automatic int f_inv(input int a);
        for (int x = 1; x < 16; x++) if (f_mul(a, x) == 1) return x;
        return 0;
    endfunction

    function automatic int f_ref(input int o, input int a, input int b);
        case (o)
            0: return f_mul(a, b);
            1: return f_inv(a);
            2: return f_mul(f_mul(a, a), 14);
            default: return a;
        endcase
    endfunction

    function automatic string f_tag(input int o);
        case (o)
            0: return "R1";
            1: return "R2";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    // cycle model
    int    m_res = 0;
    bit    m_val = 1'b0;
    string m_tag = "R8";

    always @(posedge clk) begin
        if (rst) begin
            m_res <= 0;
            m_val <= 1'b0;
            m_tag <= "R8";
            armed <= 1'b1;
        end else begin
            m_val <= in_valid;
            if (in_valid) begin
                m_res <= f_ref(int'(op), int'(opa), int'(opb));
                m_tag <= f_tag(int'(op));
            end else begin
                m_tag <= "R9";
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !done) begin
            chk("R7 out_valid", int'(out_valid), int'(m_val));
            chk(m_tag, int'(res), m_res);
        end
    end

    task automatic apply(input logic [1:0] o, input logic [3:0] a, input logic [3:0] b);
        in_valid = 1'b1;
        op  = o;
        opa = a;
        opb = b;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        op  = 2'b00;
        opa = 4'h5;
        opb = 4'ha;
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        logic [3:0] r_inv;
        logic [3:0] held;
        repeat (3) @(negedge clk);
        chk("R8 reset res", int'(res), 0);
        chk("R8 reset valid", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);

        // R1 and R4: every operand pair, back to back
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                apply(2'b00, 4'(a), 4'(b));
                chk("R1", int'(res), f_mul(a, b));
                if (b == 0) chk("R4 zero", int'(res), 0);
                if (b == 1) chk("R4 one", int'(res), a);
            end
        end
        idle(2);

        // R2 and R3: inverse, product with inverse, double inverse
        for (int a = 0; a < 16; a++) begin
            apply(2'b01, 4'(a), 4'(15 - a));
            r_inv = res;
            if (a == 0) chk("R2 zero", int'(r_inv), 0);
            apply(2'b00, 4'(a), r_inv);
            if (a != 0) chk("R2 a*inv", int'(res), 1);
            apply(2'b01, r_inv, 4'(a));
            chk("R3 involution", int'(res), a);
        end
        idle(1);

        // R5: square times lambda, opb varied
        for (int a = 0; a < 16; a++) begin
            apply(2'b10, 4'(a), 4'($urandom_range(0, 15)));
            chk("R5", int'(res), f_mul(f_mul(a, a), 14));
        end

        // R6: pass and opb independence
        for (int a = 0; a < 16; a++) begin
            apply(2'b11, 4'(a), 4'($urandom_range(0, 15)));
            chk("R6 pass", int'(res), a);
            apply(2'b01, 4'(a), 4'(a ^ 4'hf));
            chk("R6 opb ignored", int'(res), f_inv(a));
        end

        // R9: hold across idle cycles with changing inputs
        apply(2'b00, 4'h7, 4'hb);
        held = res;
        idle(4);
        chk("R9 hold", int'(res), int'(held));
        chk("R7 idle valid", int'(out_valid), 0);

        // R8: reset in mid-run
        apply(2'b11, 4'hc, 4'h0);
        rst = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        chk("R8 mid res", int'(res), 0);
        chk("R8 mid valid", int'(out_valid), 0);
        rst = 1'b0;
        idle(2);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule